// File: doc/BRIEF.md
# Serial Port Status Flag Bank

This block keeps the seven status flags of a UART-style serial port. It tracks transmit-holding-empty, transmit-finished, receive-full, line-idle, overrun, noise and framing error. The transmit and receive datapaths do not appear here. They are represented by single-cycle event strobes and a line-busy level. A small CPU bus port lets software read the packed status byte and read or write the data register. A read of the data register returns the last received byte. A write to it loads the transmit holding byte.

Flags clear only through a two-step handshake. First, a status read must observe the flag at 1, which arms it. Second, the matching data-register access clears the armed flag: a write for the transmit pair, a read for the receive and error flags. Three enables gate the transmit-empty, transmit-finished and receive-full flags into one registered interrupt request.

Top module: `uart_flag_bank`

## Requirements
- R1: The status byte places transmit-empty at bit 7, transmit-finished at bit 6, receive-full at bit 5, idle at bit 4, overrun at bit 3, noise at bit 2 and framing error at bit 1, with bit 0 always 0. A bus read with `bus_addr`=0 returns this byte on `bus_rdata` one cycle later, and `flags_o` always shows it live.
- R2: While `rst` is high the status byte becomes 8'hC0: both transmit flags are set and every other flag is cleared.
- R3: A pulse on `tx_move_i` sets transmit-empty at the next clock edge.
- R4: Transmit-finished sets at a clock edge where transmit-empty is (or is being) set, `tx_busy_i` is low and no data write occurs. It never sets while `tx_busy_i` is high.
- R5: A pulse on `rx_move_i` sets receive-full and captures `rx_byte_i`. A bus read with `bus_addr`=1 returns the captured byte one cycle later.
- R6: Pulses on `idle_i`, `overrun_i`, `noise_i` and `frame_err_i` each set their own flag.
- R7: Transmit-empty and transmit-finished clear on a data write (`bus_addr`=1) only if an earlier status read observed that flag at 1.
- R8: Receive-full and the four error flags clear on a data read only if an earlier status read observed that flag at 1.
- R9: A status read that sees a flag at 0 does not arm it. A data access with no prior arming status read leaves a set flag at 1.
- R10: If a set event and the arming-completing data access happen in the same cycle, the flag stays 1 and is disarmed, so a following data access alone does not clear it.
- R11: A bus write with `bus_addr`=0 changes no flag and arms nothing.
- R12: `irq_o` is registered and goes high one cycle after any of these is true: (transmit-empty and `irq_en_i[0]`), (transmit-finished and `irq_en_i[1]`), or (receive-full and `irq_en_i[2]`).
- R13: A data write places `bus_wdata` on `tx_hold_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 1 | 0 = status byte, 1 = data register |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Registered bus read data |
| tx_move_i | input | 1 | Holding byte moved into transmit shifter |
| tx_busy_i | input | 1 | Data, preamble or break on the line |
| rx_move_i | input | 1 | Receive shifter moved a byte to the data register |
| rx_byte_i | input | DATA_W | Byte delivered with `rx_move_i` |
| idle_i | input | 1 | Idle line detected |
| overrun_i | input | 1 | Overrun detected |
| noise_i | input | 1 | Noise detected |
| frame_err_i | input | 1 | Framing error detected |
| irq_en_i | input | 3 | Interrupt enables: [0] tx-empty, [1] tx-finished, [2] rx-full |
| flags_o | output | 8 | Live status byte |
| tx_hold_o | output | DATA_W | Transmit holding byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The clear handshake is tried four ways: a correct read-then-access, an access with no status read, a status read that saw the flag at 0, and an access that collides with a new set event. Together these separate real arming from clearing on any data access. The transmit pair is stepped with the line busy and then idle, which shows that transmit-finished waits for the line independently of transmit-empty. The error flags and a status-register write show that clearing keys on direction and address. Enabled and disabled interrupt sources check the gating and its one-cycle delay.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int NFLAG  = 7;
  // index i of the flag vector is status bit i+1
  localparam int F_FRM  = 0;
  localparam int F_NSE  = 1;
  localparam int F_OVR  = 2;
  localparam int F_IDL  = 3;
  localparam int F_RXF  = 4;
  localparam int F_TXD  = 5;
  localparam int F_TXE  = 6;
  // reset value per flag
  localparam logic [NFLAG-1:0] RST_MASK = 7'b110_0000;
  // flags cleared by a data write (others by a data read)
  localparam logic [NFLAG-1:0] WR_MASK  = 7'b110_0000;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o,
  output logic armed_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= RST_VAL;
      armed_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      if (clr_acc_i) armed_o <= 1'b0;
      else if (stat_rd_i) armed_o <= flag_o;
    end else if (clr_acc_i && armed_o) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (stat_rd_i) begin
      armed_o <= flag_o;
    end
  end

  assert_reset_value_R2: assert property (@(posedge clk)
    rst |=> (flag_o == RST_VAL && !armed_o));
  // covers R3, R5, R6
  assert_set_on_event_R6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_hold_unarmed_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !armed_o && !stat_rd_i) |=> flag_o);
  assert_no_arm_on_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !flag_o && !set_i) |=> !armed_o);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_acc_i) |=> (flag_o && !armed_o));
endmodule

// File: rtl/uart_flag_bus.sv
module uart_flag_bus #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [7:0]        status_i,
  input  logic              rx_move_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              stat_rd_o,
  output logic              data_rd_o,
  output logic              data_wr_o,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_hold_o
);
  import uart_flag_pkg::*;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] stat_ext;

  assign stat_rd_o = bus_rd && (bus_addr == ADDR_STAT);
  assign data_rd_o = bus_rd && (bus_addr == ADDR_DATA);
  assign data_wr_o = bus_wr && (bus_addr == ADDR_DATA);

  generate
    if (DATA_W > 8) begin : g_wide
      assign stat_ext = {{(DATA_W-8){1'b0}}, status_i};
    end else begin : g_narrow
      assign stat_ext = status_i[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf    <= '0;
      tx_hold_o <= '0;
      bus_rdata <= '0;
    end else begin
      if (rx_move_i) rx_buf <= rx_byte_i;
      if (data_wr_o) tx_hold_o <= bus_wdata;
      if (stat_rd_o) bus_rdata <= stat_ext;
      else if (data_rd_o) bus_rdata <= rx_buf;
    end
  end

  assert_tx_hold_load_R13: assert property (@(posedge clk) disable iff (rst)
    data_wr_o |=> (tx_hold_o == $past(bus_wdata)));
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(src_i & en_i);
  end

  assert_irq_raise_R12: assert property (@(posedge clk) disable iff (rst)
    (|(src_i & en_i)) |=> irq_o);
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_move_i,
  input  logic              tx_busy_i,
  input  logic              rx_move_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              idle_i,
  input  logic              overrun_i,
  input  logic              noise_i,
  input  logic              frame_err_i,
  input  logic [2:0]        irq_en_i,
  output logic [7:0]        flags_o,
  output logic [DATA_W-1:0] tx_hold_o,
  output logic              irq_o
);
  import uart_flag_pkg::*;

  logic             stat_rd, data_rd, data_wr;
  logic [NFLAG-1:0] set_vec, clr_vec, flag_vec, arm_vec;
  logic             txd_set;

  // transmit-finished follows transmit-empty only while the line is quiet
  assign txd_set = !tx_busy_i &&
                   (tx_move_i || (flag_vec[F_TXE] && !data_wr));

  assign set_vec[F_TXE] = tx_move_i;
  assign set_vec[F_TXD] = txd_set;
  assign set_vec[F_RXF] = rx_move_i;
  assign set_vec[F_IDL] = idle_i;
  assign set_vec[F_OVR] = overrun_i;
  assign set_vec[F_NSE] = noise_i;
  assign set_vec[F_FRM] = frame_err_i;

  genvar i;
  generate
    for (i = 0; i < NFLAG; i++) begin : g_flag
      assign clr_vec[i] = WR_MASK[i] ? data_wr : data_rd;
      uart_flag_cell #(.RST_VAL(RST_MASK[i])) u_cell (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec[i]),
        .stat_rd_i(stat_rd),
        .clr_acc_i(clr_vec[i]),
        .flag_o   (flag_vec[i]),
        .armed_o  (arm_vec[i])
      );
    end
  endgenerate

  assign flags_o = {flag_vec, 1'b0};

  uart_flag_bus #(.DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .status_i (flags_o),
    .rx_move_i(rx_move_i),
    .rx_byte_i(rx_byte_i),
    .stat_rd_o(stat_rd),
    .data_rd_o(data_rd),
    .data_wr_o(data_wr),
    .bus_rdata(bus_rdata),
    .tx_hold_o(tx_hold_o)
  );

  uart_flag_irq #(.NSRC(3)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .src_i({flag_vec[F_RXF], flag_vec[F_TXD], flag_vec[F_TXE]}),
    .en_i (irq_en_i),
    .irq_o(irq_o)
  );

  assert_txd_blocked_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_busy_i && !flag_vec[F_TXD]) |=> !flag_vec[F_TXD]);
  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_STAT && set_vec == '0) |=>
      (flag_vec == $past(flag_vec) && arm_vec == $past(arm_vec)));
  assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> !bus_rdata[0]);
endmodule

// File: tb/sim_uart_flag_bank.sv
module sim_uart_flag_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata, rx_byte = '0, flags, tx_hold;
  logic       tx_move = 0, tx_busy = 0, rx_move = 0;
  logic       idle = 0, ovr = 0, nse = 0, frm = 0, irq;
  logic [2:0] irq_en = '0;
  int n_run = 0, n_fail = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  uart_flag_bank #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_move_i(tx_move),
    .tx_busy_i(tx_busy), .rx_move_i(rx_move), .rx_byte_i(rx_byte),
    .idle_i(idle), .overrun_i(ovr), .noise_i(nse), .frame_err_i(frm),
    .irq_en_i(irq_en), .flags_o(flags), .tx_hold_o(tx_hold), .irq_o(irq));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(logic a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic t_reset();
    check("R2 reset flags", flags, 8'hC0);
    check("R12 irq idle after reset", {7'd0, irq}, 8'h00);
    bus_read(0, rd);
    check("R1 status read", rd, 8'hC0);
  endtask

  task automatic t_tx();
    bus_read(0, rd);
    bus_write(1, 8'h5A);
    check("R7 tx pair cleared", flags, 8'h00);
    check("R13 tx hold", tx_hold, 8'h5A);
    tx_busy = 1; tx_move = 1; tick(); tx_move = 0;
    check("R3/R4 empty set, finished held while busy", flags, 8'h80);
    bus_read(0, rd);
    check("R1 status read returns 80", rd, 8'h80);
    tx_busy = 0; tick();
    check("R4 finished sets when line idle", flags, 8'hC0);
    bus_write(1, 8'h22);
    check("R9 unarmed finished survives write", flags, 8'h40);
    bus_read(0, rd);
    bus_write(1, 8'h33);
    check("R7 finished cleared", flags, 8'h00);
  endtask

  task automatic t_rx();
    rx_byte = 8'h3C; rx_move = 1; tick(); rx_move = 0;
    check("R5 rx full set", flags, 8'h20);
    bus_read(0, rd);
    bus_read(1, rd);
    check("R5 rx byte read", rd, 8'h3C);
    check("R8 rx full cleared", flags, 8'h00);
  endtask

  task automatic t_collide();
    rx_byte = 8'h3C; rx_move = 1; tick(); rx_move = 0;
    bus_read(0, rd);
    rx_byte = 8'h77; rx_move = 1; bus_rd = 1; bus_addr = 1; tick();
    rx_move = 0; bus_rd = 0; rd = bus_rdata;
    check("R10 old byte returned", rd, 8'h3C);
    check("R10 set wins", flags, 8'h20);
    bus_read(1, rd);
    check("R10 disarmed, still full", flags, 8'h20);
    check("R5 new byte", rd, 8'h77);
    bus_read(0, rd);
    bus_read(1, rd);
    check("R8 cleared after rearm", flags, 8'h00);
  endtask

  task automatic t_errors();
    idle = 1; ovr = 1; nse = 1; frm = 1; tick();
    idle = 0; ovr = 0; nse = 0; frm = 0;
    check("R6 error flags set", flags, 8'h1E);
    bus_read(1, rd);
    check("R9 data read without arming", flags, 8'h1E);
    bus_read(0, rd);
    check("R1 status shows errors", rd, 8'h1E);
    bus_read(1, rd);
    check("R8 error flags cleared", flags, 8'h00);
  endtask

  task automatic t_stat_write();
    idle = 1; tick(); idle = 0;
    bus_write(0, 8'h00);
    check("R11 status write no effect", flags, 8'h10);
    bus_read(1, rd);
    check("R11 status write arms nothing", flags, 8'h10);
    bus_read(0, rd);
    bus_read(1, rd);
    check("R8 idle cleared", flags, 8'h00);
  endtask

  task automatic t_irq();
    irq_en = 3'b011; tick(); tick();
    check("R12 tx enables with tx flags clear", {7'd0, irq}, 8'h00);
    irq_en = 3'b100;
    rx_byte = 8'h01; rx_move = 1; tick(); rx_move = 0;
    check("R12 irq one cycle after flag", {7'd0, irq}, 8'h00);
    tick();
    check("R12 rx irq raised", {7'd0, irq}, 8'h01);
    irq_en = 3'b000; tick();
    check("R12 irq masked", {7'd0, irq}, 8'h00);
    bus_read(0, rd);
    bus_read(1, rd);
    check("R8 rx cleared", flags, 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_tx();
    t_rx();
    t_collide();
    t_errors();
    t_stat_write();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule